// File: doc/BRIEF.md
# Cache Tour Locality Classifier

This block sits beside a direct-mapped data cache and watches its access stream. For every cache line it keeps a record of the residency now in progress. A residency, called a tour, starts when a block is filled into the line and ends when another block replaces it. The record holds one bit per word offset, set once that word has been touched, and a sticky flag that is set when a word is touched a second time.

When a tour ends, the block reports two things in the same cycle. The first is a two-bit locality class: bit 1 is temporal reuse and bit 0 is spatial spread. The second is a two-bit placement hint derived from that class. A saturating counter per class records how many tours have finished in it.

A flush request ends every live tour. It walks the lines in ascending order, one line per cycle, reports each valid line, and leaves all history cleared. The block stores no tags and no data; the cache controller says which accesses are fills.

Top module: `tour_classifier`

## Requirements
- R1: After reset every line is empty, all four counters read zero and `cls_valid` is low.
- R2: A fill access starts a new tour on the line selected by address bits [OFF_W+IDX_W-1:OFF_W]. The word at address bits [OFF_W-1:0] counts as that tour's first touch, so a single later access to the same word already marks reuse.
- R3: The class is {temporal, spatial}. Temporal means some word was touched more than once in the tour. Spatial means more than one distinct word was touched. This gives 2'b11 for both, 2'b10 for reuse of a single word, 2'b01 for several words each touched once, and 2'b00 for one word touched once.
- R4: A fill to a line holding a live tour raises `cls_valid` combinationally in the same cycle, with the old tour's class and `cls_line` equal to the line index. A fill to an empty line raises no event.
- R5: The hint is a fixed function of the class: class 2'b11 gives 2'b00 (cache normally), 2'b10 gives 2'b01 (keep the touched word only), 2'b01 gives 2'b10 (buffer only), and 2'b00 gives 2'b11 (bypass).
- R6: At the clock edge that ends each event cycle, exactly the counter of the reported class increases by one. Counters are `cnt_ts` (2'b11), `cnt_tns` (2'b10), `cnt_nts` (2'b01) and `cnt_ntns` (2'b00).
- R7: A counter at its all-ones value stays there.
- R8: A non-fill access to an empty line is ignored and starts no tour.
- R9: A flush sampled at a clock edge is followed by LINES cycles. In cycle i, line i is reported if it was valid and nothing is reported otherwise. After these cycles every line is empty.
- R10: Accesses are ignored in the cycle a flush is sampled and during the LINES cycles that follow.
- R11: Activity on one line never changes the history of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Word address of the access |
| acc_fill | input | 1 | The access brings a new block into its line |
| flush | input | 1 | End and classify every live tour |
| cls_valid | output | 1 | Tour-end event this cycle |
| cls_class | output | 2 | Class of the ending tour, {temporal, spatial} |
| cls_hint | output | 2 | Placement hint for the ending tour |
| cls_line | output | IDX_W | Line whose tour ended |
| cnt_ts | output | CNT_W | Tours with reuse and spread |
| cnt_tns | output | CNT_W | Tours with reuse of one word |
| cnt_nts | output | CNT_W | Tours with spread and no reuse |
| cnt_ntns | output | CNT_W | Tours with one word touched once |

## Verification
A wrong touch bitmap or repeat flag stays hidden until the line's tour ends. It then shows as a wrong `cls_class` and `cls_hint` in the cycle of the replacing fill or the flush step, and as the wrong counter moving one edge later. A wrong valid bit shows earlier: it either produces an event on a fill to an empty line or drops one on a replacement. A broken flush walk shows as events in the wrong cycle or as stale lines reporting after the flush. The bench replays every access against a line-by-line model, so each event and every counter is compared at the first cycle it could differ.

// File: rtl/tour_classifier.sv
module tour_classifier #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_fill,
  input  logic              flush,
  output logic              cls_valid,
  output logic [1:0]        cls_class,
  output logic [1:0]        cls_hint,
  output logic [IDX_W-1:0]  cls_line,
  output logic [CNT_W-1:0]  cnt_ts,
  output logic [CNT_W-1:0]  cnt_tns,
  output logic [CNT_W-1:0]  cnt_nts,
  output logic [CNT_W-1:0]  cnt_ntns
);

  logic [WORDS-1:0] bmap [LINES];
  logic [LINES-1:0] rep, vld;
  logic             fl_act;
  logic [IDX_W-1:0] fl_idx;
  logic [CNT_W-1:0] cnt [4];

  wire [OFF_W-1:0] off    = acc_addr[OFF_W-1:0];
  wire [IDX_W-1:0] idx    = acc_addr[OFF_W +: IDX_W];
  wire [WORDS-1:0] touch  = {{(WORDS-1){1'b0}}, 1'b1} << off;
  wire             acc_ok = acc_valid && !fl_act && !flush;
  wire [IDX_W-1:0] ev_line = fl_act ? fl_idx : idx;
  wire [WORDS-1:0] ev_bm   = bmap[ev_line];

  assign cls_valid = fl_act ? vld[fl_idx] : (acc_ok && acc_fill && vld[idx]);
  assign cls_line  = ev_line;
  assign cls_class = {rep[ev_line], (ev_bm & (ev_bm - WORDS'(1))) != '0};

  always_comb begin
    case (cls_class)
      2'b11:   cls_hint = 2'b00;
      2'b10:   cls_hint = 2'b01;
      2'b01:   cls_hint = 2'b10;
      default: cls_hint = 2'b11;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rep    <= '0;
      fl_act <= 1'b0;
      fl_idx <= '0;
      for (int i = 0; i < LINES; i++) bmap[i] <= '0;
    end else if (fl_act) begin
      vld[fl_idx]  <= 1'b0;
      rep[fl_idx]  <= 1'b0;
      bmap[fl_idx] <= '0;
      fl_idx       <= fl_idx + IDX_W'(1);
      if (fl_idx == IDX_W'(LINES - 1)) fl_act <= 1'b0;
    end else if (flush) begin
      fl_act <= 1'b1;
      fl_idx <= '0;
    end else if (acc_ok) begin
      if (acc_fill) begin
        vld[idx]  <= 1'b1;
        rep[idx]  <= 1'b0;
        bmap[idx] <= touch;
      end else if (vld[idx]) begin
        rep[idx]  <= rep[idx] | (|(bmap[idx] & touch));
        bmap[idx] <= bmap[idx] | touch;
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cnt[g] <= '0;
      else if (cls_valid && cls_class == 2'(g) && cnt[g] != '1)
        cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end

  assign cnt_ts   = cnt[3];
  assign cnt_tns  = cnt[2];
  assign cnt_nts  = cnt[1];
  assign cnt_ntns = cnt[0];

  // R4
  event_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_valid |-> (fl_act || (acc_valid && acc_fill)));

  // R6
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_class == 2'b11 && cnt_ts != '1) |=> cnt_ts == $past(cnt_ts) + CNT_W'(1));

  // R6
  quiet_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_valid |=> ($stable(cnt_ts) && $stable(cnt_tns) && $stable(cnt_nts) && $stable(cnt_ntns)));

  // R7
  ntns_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ntns == '1 |=> cnt_ntns == '1);

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_act) |-> vld == '0);

  // R2
  fill_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && acc_fill) |=> (vld[$past(idx)] && !rep[$past(idx)]));

endmodule

// File: tb/test_tour_classifier.sv
module test_tour_classifier;
  localparam int CLK_P = 10;
  localparam int LINES = 8;
  localparam int WORDS = 4;
  localparam int CMAX  = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_fill = 1'b0, flush = 1'b0;
  logic [15:0] acc_addr = '0;
  logic cls_valid;
  logic [1:0] cls_class, cls_hint;
  logic [2:0] cls_line;
  logic [3:0] cnt_ts, cnt_tns, cnt_nts, cnt_ntns;

  tour_classifier #(.LINES(LINES), .WORDS(WORDS), .ADDR_W(16), .CNT_W(4)) i_tour_classifier (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_fill(acc_fill), .flush(flush), .cls_valid(cls_valid), .cls_class(cls_class),
    .cls_hint(cls_hint), .cls_line(cls_line), .cnt_ts(cnt_ts), .cnt_tns(cnt_tns),
    .cnt_nts(cnt_nts), .cnt_ntns(cnt_ntns));

  always #(CLK_P/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, tagc = 1;
  bit done = 0;
  logic [3:0] m_bm [LINES];
  bit m_rep [LINES], m_vld [LINES];
  int m_cnt [4];
  bit last_v; int last_cls, last_hint;

  task automatic chk(string req, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int m_class(int l);
    return (m_rep[l] ? 2 : 0) + (($countones(m_bm[l]) > 1) ? 1 : 0);
  endfunction

  function automatic int m_hint(int c);
    case (c)
      3: return 0;
      2: return 1;
      1: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic chk_cnts(string req);
    chk(req, cnt_ts,   m_cnt[3], "cnt_ts");
    chk(req, cnt_tns,  m_cnt[2], "cnt_tns");
    chk(req, cnt_nts,  m_cnt[1], "cnt_nts");
    chk(req, cnt_ntns, m_cnt[0], "cnt_ntns");
  endtask

  task automatic chk_event(string req, bit ev, int line);
    chk(req, cls_valid, ev, "cls_valid");
    last_v = cls_valid;
    last_cls = cls_class;
    last_hint = cls_hint;
    if (ev) begin
      chk(req, cls_class, m_class(line), "cls_class");
      chk(req, cls_hint, m_hint(m_class(line)), "cls_hint");
      chk(req, cls_line, line, "cls_line");
      if (m_cnt[m_class(line)] < CMAX) m_cnt[m_class(line)]++;
    end
  endtask

  task automatic acc(int line, int off, bit fill, string req);
    @(negedge clk);
    if (fill) tagc++;
    acc_valid = 1'b1;
    acc_fill = fill;
    acc_addr = 16'(tagc * 32 + line * 4 + off);
    #1;
    chk_event(req, fill && m_vld[line], line);
    if (fill) begin
      m_vld[line] = 1; m_rep[line] = 0; m_bm[line] = 4'(1 << off);
    end else if (m_vld[line]) begin
      m_rep[line] = m_rep[line] | (|(m_bm[line] & 4'(1 << off)));
      m_bm[line] = m_bm[line] | 4'(1 << off);
    end
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_fill = 1'b0;
    chk_cnts(req);
  endtask

  task automatic t_reset();
    chk("R1", cls_valid, 0, "cls_valid");
    chk_cnts("R1");
  endtask

  task automatic t_ts();
    acc(1, 0, 1, "R2"); acc(1, 0, 0, "R2"); acc(1, 2, 0, "R2");
    acc(1, 1, 1, "R4");
    chk("R3", last_cls, 3, "TS code"); chk("R5", last_hint, 0, "TS hint");
  endtask

  task automatic t_tns();
    acc(2, 3, 1, "R2"); acc(2, 3, 0, "R2"); acc(2, 3, 0, "R2");
    acc(2, 0, 1, "R4");
    chk("R3", last_cls, 2, "TNS code"); chk("R5", last_hint, 1, "TNS hint");
  endtask

  task automatic t_nts();
    acc(3, 0, 1, "R2"); acc(3, 1, 0, "R11"); acc(3, 2, 0, "R11"); acc(3, 3, 0, "R11");
    acc(3, 2, 1, "R4");
    chk("R3", last_cls, 1, "NTS code"); chk("R5", last_hint, 2, "NTS hint");
  endtask

  task automatic t_ntns();
    acc(4, 2, 1, "R4");
    chk("R4", last_v, 0, "fill into empty line");
    acc(4, 1, 1, "R4");
    chk("R3", last_cls, 0, "NTNS code"); chk("R5", last_hint, 3, "NTNS hint");
    acc(5, 1, 1, "R2"); acc(5, 1, 0, "R2"); acc(5, 0, 1, "R2");
    chk("R2", last_cls, 2, "fill word counted as first touch");
  endtask

  task automatic t_empty();
    acc(6, 0, 0, "R8"); acc(6, 0, 0, "R8");
    acc(6, 0, 1, "R8");
    chk("R8", last_v, 0, "no tour from plain access");
    acc(6, 1, 1, "R8");
    chk("R8", last_cls, 0, "fresh tour only");
  endtask

  task automatic t_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      chk_event("R9", m_vld[i], i);
      if (i == 2) begin
        acc_valid = 1'b1; acc_fill = 1'b1; acc_addr = 16'(7 * 4);
      end
      @(posedge clk); #1;
      acc_valid = 1'b0; acc_fill = 1'b0;
    end
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 0; m_rep[i] = 0; m_bm[i] = '0;
    end
    chk("R9", cls_valid, 0, "idle after flush");
    chk_cnts("R9");
    acc(7, 0, 1, "R10");
    chk("R10", last_v, 0, "fill during flush ignored");
    acc(1, 0, 1, "R9");
    chk("R9", last_v, 0, "line cleared by flush");
  endtask

  task automatic t_sat();
    for (int k = 0; k < 20; k++) acc(0, 3, 1, "R7");
    chk("R7", cnt_ntns, CMAX, "saturated");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_vld[i] = 0; m_rep[i] = 0; m_bm[i] = '0;
    end
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    t_reset();
    t_ts();
    t_tns();
    t_nts();
    t_ntns();
    t_empty();
    t_flush();
    t_sat();
    done = 1;
    finish_run();
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule